// File: doc/BRIEF.md
# Machine-Mode Control Register File

This block holds the machine-level control and status state of a small 32-bit core. Each cycle it can take one request. A request carries a 12-bit register number, a two-bit operation code and a 32-bit operand. The operation is a read, a replace, a bit-set or a bit-clear. The block returns the addressed register's contents as they stood before the request. In the same clock edge it updates that register. The response is registered, so it appears one cycle after the request.

Ten registers are decoded:

| Register | Number |
|----------|--------|
| status | 0x300 |
| ISA identity | 0x301 |
| interrupt enable | 0x304 |
| trap vector | 0x305 |
| scratch | 0x340 |
| exception PC | 0x341 |
| cause | 0x342 |
| trap value | 0x343 |
| interrupt pending | 0x344 |
| second trap value | 0x34B |

Many fields are hardwired to zero. Only the bits a machine-only core needs can hold state. Any other number is flagged as an illegal access. Trap sequencing, privilege checking and interrupt arbitration belong to the core around this block.

Top module: `mcsr_file`

## Requirements
- R1: Only numbers 0x300, 0x301, 0x304, 0x305, 0x340, 0x341, 0x342, 0x343, 0x344 and 0x34B are decoded. An accepted request to any other number raises rsp_illegal in the response cycle, returns zero read data and changes no register.
- R2: A request accepted while req_valid is high produces rsp_valid high on the next cycle. When req_valid is low, no register changes and rsp_valid is low on the next cycle. rsp_rdata is the register value as it stood before that request's update.
- R3: Operation code 2'b01 replaces the writable bits with the operand.
- R4: Operation code 2'b10 ORs the operand into the register.
- R5: Operation code 2'b11 computes old AND NOT operand, so bits that are already zero stay zero.
- R6: Operation code 2'b00 reads without changing the register.
- R7: After a synchronous active-high reset, the ISA identity register reads 0x40001100. In that value, bit 30 gives the 32-bit width and bits 8 and 12 mark the base-integer and multiply extensions. The status register reads 0x00001800, with previous-privilege bits 12:11 = 2'b11. Every other register reads zero.
- R8: The ISA identity register is read-only: writes, sets and clears leave it at 0x40001100.
- R9: In the status register only bit 3 (global interrupt enable), bit 7 (previous enable) and bits 12:11 (previous privilege) hold state. All other bits read zero.
- R10: In the interrupt-enable and interrupt-pending registers only bits 1, 3, 5, 7, 9 and 11 hold state. All other bits read zero.
- R11: Bits 1:0 of the exception PC always read zero.
- R12: The trap vector, scratch, cause (bit 31 = interrupt flag, bits 30:0 = code), trap value and second trap value registers hold all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register number |
| req_op | input | 2 | 00 read, 01 replace, 10 set, 11 clear |
| req_operand | input | 32 | Source operand |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | 32 | Pre-update register value, zero when illegal |
| rsp_illegal | output | 1 | Request addressed an undecoded number |

## Verification
A wrong internal state becomes visible only when the affected register is read. The read data appears on rsp_rdata in the cycle after the request. So the bench follows every modifying request with a read of the same register, which shows any corruption within two cycles.

The constant fields are checked after each access. These are the ISA identity value and the hardwired zeros of status, the interrupt registers and the exception PC. A write that leaks into a hardwired bit therefore shows on the very next read. A clear built from XOR shows up by clearing a bit that is already zero.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int XLEN   = 32;
  localparam int ADDR_W = 12;
  localparam int NREG   = 10;

  typedef logic [XLEN-1:0]   word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  // Register numbers seen by the instruction decoder
  localparam addr_t A_STATUS  = 12'h300;
  localparam addr_t A_ISA     = 12'h301;
  localparam addr_t A_IENABLE = 12'h304;
  localparam addr_t A_TVEC    = 12'h305;
  localparam addr_t A_SCRATCH = 12'h340;
  localparam addr_t A_EPC     = 12'h341;
  localparam addr_t A_CAUSE   = 12'h342;
  localparam addr_t A_TVAL    = 12'h343;
  localparam addr_t A_IPEND   = 12'h344;
  localparam addr_t A_TVAL2   = 12'h34B;

  // Field masks and identity constants
  localparam word_t STATUS_WMASK = 32'h0000_1888;
  localparam word_t INT_WMASK    = 32'h0000_0AAA;
  localparam word_t EPC_WMASK    = 32'hFFFF_FFFC;
  localparam word_t FULL_WMASK   = 32'hFFFF_FFFF;
  localparam word_t ISA_RST      = 32'h4000_1100;
  localparam word_t STATUS_RST   = 32'h0000_1800;

  localparam addr_t REG_ADDR [NREG] = '{
    A_STATUS, A_ISA, A_IENABLE, A_TVEC, A_SCRATCH,
    A_EPC, A_CAUSE, A_TVAL, A_IPEND, A_TVAL2
  };

  localparam word_t REG_WMASK [NREG] = '{
    STATUS_WMASK, 32'h0, INT_WMASK, FULL_WMASK, FULL_WMASK,
    EPC_WMASK, FULL_WMASK, FULL_WMASK, INT_WMASK, FULL_WMASK
  };

  localparam word_t REG_RST [NREG] = '{
    STATUS_RST, ISA_RST, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0
  };

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter int N = NREG
) (
  input  logic         req_valid,
  input  addr_t        addr,
  output logic [N-1:0] sel,
  output logic         hit,
  output logic         illegal
);

  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = (addr == REG_ADDR[i]);
  end

  assign sel     = req_valid ? match : '0;
  assign hit     = |sel;
  assign illegal = req_valid && (match == '0);

endmodule

// File: rtl/mcsr_update.sv
module mcsr_update
  import mcsr_pkg::*;
(
  input  csr_op_e op,
  input  word_t   old_val,
  input  word_t   operand,
  output word_t   new_val,
  output logic    modify
);

  always_comb begin
    new_val = old_val;
    modify  = 1'b1;
    unique case (op)
      OP_WRITE: new_val = operand;
      OP_SET:   new_val = old_val | operand;
      OP_CLEAR: new_val = old_val & ~operand;
      default:  modify  = 1'b0;
    endcase
  end

endmodule

// File: rtl/mcsr_bank.sv
module mcsr_bank
  import mcsr_pkg::*;
#(
  parameter int N = NREG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sel,
  input  logic         we,
  input  word_t        wdata,
  output word_t        rdata
);

  word_t q [N];
  word_t gated [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam word_t WM = REG_WMASK[i];
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= REG_RST[i];
      else if (we && sel[i])
        q[i] <= (q[i] & ~WM) | (wdata & WM);
    end
    assign gated[i] = sel[i] ? q[i] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      rdata = rdata | gated[i];
  end

endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [11:0] req_addr,
  input  logic [1:0]  req_op,
  input  logic [31:0] req_operand,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_illegal
);

  logic [NREG-1:0] sel;
  logic            hit;
  logic            illegal;
  word_t           old_val;
  word_t           new_val;
  logic            modify;

  mcsr_decode #(.N(NREG)) u_dec (
    .req_valid (req_valid),
    .addr      (req_addr),
    .sel       (sel),
    .hit       (hit),
    .illegal   (illegal)
  );

  mcsr_bank #(.N(NREG)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .we    (modify && hit),
    .wdata (new_val),
    .rdata (old_val)
  );

  mcsr_update u_upd (
    .op      (csr_op_e'(req_op)),
    .old_val (old_val),
    .operand (req_operand),
    .new_val (new_val),
    .modify  (modify)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= hit ? old_val : '0;
      rsp_illegal <= illegal;
    end
  end

endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk
  import mcsr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [11:0] req_addr,
  input logic [1:0]  req_op,
  input logic [31:0] req_operand,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_illegal
);

  logic known;
  assign known = (req_addr == A_STATUS)  || (req_addr == A_ISA)   ||
                 (req_addr == A_IENABLE) || (req_addr == A_TVEC)  ||
                 (req_addr == A_SCRATCH) || (req_addr == A_EPC)   ||
                 (req_addr == A_CAUSE)   || (req_addr == A_TVAL)  ||
                 (req_addr == A_IPEND)   || (req_addr == A_TVAL2);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_ILLEGAL_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (rsp_valid && rsp_rdata == 32'h0)); // R1
  AST_UNKNOWN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !known) |=> rsp_illegal); // R1
  AST_KNOWN_NOT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && known) |=> !rsp_illegal); // R1
  AST_ISA_CONSTANT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == A_ISA) |=> (rsp_rdata == ISA_RST)); // R8
  AST_STATUS_HARD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == A_STATUS) |=> ((rsp_rdata & ~STATUS_WMASK) == 32'h0)); // R9
  AST_IENABLE_HARD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == A_IENABLE) |=> ((rsp_rdata & ~INT_WMASK) == 32'h0)); // R10
  AST_IPEND_HARD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == A_IPEND) |=> ((rsp_rdata & ~INT_WMASK) == 32'h0)); // R10
  AST_EPC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == A_EPC) |=> (rsp_rdata[1:0] == 2'b00)); // R11

endmodule

bind mcsr_file mcsr_file_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_op      (req_op),
  .req_operand (req_operand),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_illegal (rsp_illegal)
);

// File: tb/mcsr_file_test.sv
`timescale 1ns/1ps
module mcsr_file_test;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] opnd;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 33;
  // op: 0 read, 1 replace, 2 set, 3 clear
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'h301, 32'h0,        32'h40001100, 1'b0}, // R7
    '{2'd0, 12'h300, 32'h0,        32'h00001800, 1'b0}, // R7
    '{2'd0, 12'h340, 32'h0,        32'h00000000, 1'b0}, // R7
    '{2'd1, 12'h301, 32'hFFFFFFFF, 32'h40001100, 1'b0}, // R8
    '{2'd0, 12'h301, 32'h0,        32'h40001100, 1'b0}, // R8
    '{2'd1, 12'h300, 32'hFFFFFFFF, 32'h00001800, 1'b0}, // R9
    '{2'd0, 12'h300, 32'h0,        32'h00001888, 1'b0}, // R9
    '{2'd3, 12'h300, 32'h00000808, 32'h00001888, 1'b0}, // R5
    '{2'd0, 12'h300, 32'h0,        32'h00001080, 1'b0}, // R5
    '{2'd3, 12'h300, 32'h00000008, 32'h00001080, 1'b0}, // R5
    '{2'd0, 12'h300, 32'h0,        32'h00001080, 1'b0}, // R5
    '{2'd1, 12'h304, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R10
    '{2'd0, 12'h304, 32'h0,        32'h00000AAA, 1'b0}, // R10
    '{2'd2, 12'h344, 32'h00000055, 32'h00000000, 1'b0}, // R10
    '{2'd2, 12'h344, 32'h00000880, 32'h00000000, 1'b0}, // R4
    '{2'd0, 12'h344, 32'h0,        32'h00000880, 1'b0}, // R10
    '{2'd1, 12'h341, 32'h12345677, 32'h00000000, 1'b0}, // R11
    '{2'd0, 12'h341, 32'h0,        32'h12345674, 1'b0}, // R11
    '{2'd1, 12'h340, 32'hDEADBEEF, 32'h00000000, 1'b0}, // R12
    '{2'd2, 12'h340, 32'h00000110, 32'hDEADBEEF, 1'b0}, // R4
    '{2'd0, 12'h340, 32'h0,        32'hDEADBFFF, 1'b0}, // R4
    '{2'd1, 12'h34B, 32'hA5A5A5A5, 32'h00000000, 1'b0}, // R3
    '{2'd1, 12'h34B, 32'h5A5A5A5A, 32'hA5A5A5A5, 1'b0}, // R3
    '{2'd0, 12'h34B, 32'h0,        32'h5A5A5A5A, 1'b0}, // R3
    '{2'd1, 12'h342, 32'h8000000B, 32'h00000000, 1'b0}, // R12
    '{2'd0, 12'h342, 32'h0,        32'h8000000B, 1'b0}, // R12
    '{2'd1, 12'h7C0, 32'hFFFFFFFF, 32'h00000000, 1'b1}, // R1
    '{2'd0, 12'h305, 32'h0,        32'h00000000, 1'b0}, // R1
    '{2'd1, 12'h305, 32'h80000101, 32'h00000000, 1'b0}, // R12
    '{2'd0, 12'h305, 32'hFFFFFFFF, 32'h80000101, 1'b0}, // R6
    '{2'd0, 12'h305, 32'h0,        32'h80000101, 1'b0}, // R6
    '{2'd0, 12'h343, 32'h0,        32'h00000000, 1'b0}, // R12
    '{2'd0, 12'h345, 32'h0,        32'h00000000, 1'b1}  // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_operand = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_illegal;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mcsr_file uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_operand(req_operand), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where the response is visible
  task automatic issue(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] exp, input logic ill, input string tag);
    req_valid   = 1'b1;
    req_op      = op;
    req_addr    = a;
    req_operand = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'h0, rsp_valid}, 32'h1);
    check({tag, " rdata"}, rsp_rdata, exp);
    check({tag, " illegal"}, {31'h0, rsp_illegal}, {31'h0, ill});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++)
      issue(VECS[i].op, VECS[i].addr, VECS[i].opnd, VECS[i].exp, VECS[i].ill,
            $sformatf("vector %0d", i));

    // R2: idle cycle with a replace presented but req_valid low
    req_valid = 1'b0; req_op = 2'd1; req_addr = 12'h340; req_operand = 32'h0;
    @(negedge clk);
    check("R2 no response when idle", {31'h0, rsp_valid}, 32'h0);
    issue(2'd0, 12'h340, 32'h0, 32'hDEADBFFF, 1'b0, "R2 idle write ignored");

    // R2: back-to-back clear then read sees pre-update then post-update value
    issue(2'd3, 12'h340, 32'hFFFF0000, 32'hDEADBFFF, 1'b0, "R2 pre-update data");
    issue(2'd0, 12'h340, 32'h0, 32'h0000BFFF, 1'b0, "R5 clear upper half");

    // R8: set and clear on the identity register
    issue(2'd3, 12'h301, 32'hFFFFFFFF, 32'h40001100, 1'b0, "R8 clear ignored");
    issue(2'd2, 12'h301, 32'h0000FFFF, 32'h40001100, 1'b0, "R8 set ignored");

    // R7: reset mid-run restores identity values
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    issue(2'd0, 12'h300, 32'h0, 32'h00001800, 1'b0, "R7 status after reset");
    issue(2'd0, 12'h340, 32'h0, 32'h00000000, 1'b0, "R7 scratch after reset");
    issue(2'd0, 12'h344, 32'h0, 32'h00000000, 1'b0, "R7 pending after reset");
    issue(2'd0, 12'h301, 32'h0, 32'h40001100, 1'b0, "R7 identity after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule